// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt requests and steers each one into one of three classes: the fast interrupt line, a vectored normal interrupt, or an unvectored normal interrupt. Each source can be raised by its hardware pin or by a software bit. Sources with their class bit set drive the fast output. The others drive the normal output. A per-source enable mask gates both outputs.

Sixteen vector slots each name one source and hold the start address of its handler. Slot order is priority order, with the lowest index winning. The handler reads the vector-address register to learn where to jump, and that read marks the slot as in service. A later write to the same register ends the service. Enabled normal sources that no slot claims share a single default address.

A small synchronous register bus, with one access per cycle and combinational read data, programs every setting and reads back the status words.

Top module: `intc_vec_top`

## Requirements
- R1: After reset, every setting, the software bits, the enable mask and the in-service state are zero. Both outputs are low, and a read of the vector-address register returns 0.
- R2: Word 0x00 reads the raw request word. Bit n is hardware pin n ORed with software bit n, regardless of enable or class.
- R3: Writing word 0x06 sets the software bits where the data has ones. Writing word 0x07 clears them. Word 0x06 reads back the software bits.
- R4: Writing word 0x04 sets enable bits and writing word 0x05 clears them, both by the ones in the data. Word 0x04 reads the mask. A source that is not enabled reaches neither output nor either class status word.
- R5: Word 0x03 holds the class bits, where 1 means fast and 0 means normal. The fast output is high when any enabled raw source has class 1, and word 0x01 shows those sources. The normal output is high when any enabled raw source has class 0, and word 0x02 shows those sources.
- R6: When no enabled slot names a source that is pending in word 0x02, and no slot is in service, a read of word 0x08 returns the default address held at word 0x09.
- R7: Slot k is programmed with its control at word 0x10+k, where bits 4:0 give the source number and bit 5 is the enable. Its address is at word 0x20+k. A slot is active when it is enabled and its source is pending in word 0x02. With nothing in service, word 0x08 returns the address of the active slot with the lowest index.
- R8: A read of word 0x08 that returns an active slot marks that slot in service. While slots are in service, only active slots with a lower index than the best in-service slot can be returned. Otherwise the best in-service slot's address is returned. Any write to word 0x08 releases the best in-service slot.
- R9: A slot whose source has class 1 is never active, even when that source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwReq | input | NUM_SRC | Level-sensitive hardware requests |
| busAddr | input | 6 | Register word address |
| busWr | input | 1 | Write strobe for this cycle |
| busRd | input | 1 | Read strobe for this cycle |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the same cycle |
| fiqOut | output | 1 | Fast interrupt request |
| irqOut | output | 1 | Normal interrupt request |

## Verification
The bench builds the controller with its default sizes: 32 sources, 16 slots and a 32-bit data path. At these sizes source 31 and slot 15, the lowest-priority corner, can be driven. The bench nests services across slots 0, 2 and 5 so that preemption by a higher slot and blocking of a lower slot both occur. It also switches a claimed source into the fast class and disables a slot, so the default address is returned while a claimed source is still pending.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BUS_AW = 6;

  localparam logic [BUS_AW-1:0] OFS_RAW      = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_FIQ_STAT = 6'h01;
  localparam logic [BUS_AW-1:0] OFS_IRQ_STAT = 6'h02;
  localparam logic [BUS_AW-1:0] OFS_CLASS    = 6'h03;
  localparam logic [BUS_AW-1:0] OFS_EN_SET   = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_EN_CLR   = 6'h05;
  localparam logic [BUS_AW-1:0] OFS_SW_SET   = 6'h06;
  localparam logic [BUS_AW-1:0] OFS_SW_CLR   = 6'h07;
  localparam logic [BUS_AW-1:0] OFS_VEC      = 6'h08;
  localparam logic [BUS_AW-1:0] OFS_DEFAULT  = 6'h09;
  localparam logic [1:0]        REGION_CTL   = 2'b01;
  localparam logic [1:0]        REGION_ADR   = 2'b10;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic classWr;
    logic enSet;
    logic enClr;
    logic swSet;
    logic swClr;
    logic defWr;
    logic slotCtlWr;
    logic slotAdrWr;
    logic vecRead;
    logic vecEnd;
  } strobe_t;
endpackage

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BUS_AW-1:0]        busAddr,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [NUM_SLOT-1:0]      slotActive,
  output strobe_t                  strobe,
  output logic [SLOT_W-1:0]        slotIdx,
  output logic                     slotHit,
  output logic [SLOT_W-1:0]        outSlot,
  output logic                     useDefault,
  output logic [NUM_SLOT-1:0]      svcMask
);
  logic              inCtl, inAdr;
  logic              blocked, candFound, svcFound;
  logic [SLOT_W-1:0] candSlot, svcSlot;

  // address decode
  always_comb begin
    inCtl   = (busAddr[5:4] == REGION_CTL);
    inAdr   = (busAddr[5:4] == REGION_ADR);
    slotHit = ({1'b0, busAddr[3:0]} < 5'(NUM_SLOT));
    slotIdx = SLOT_W'(busAddr[3:0]);
    strobe  = '0;
    if (busWr) begin
      strobe.classWr   = (busAddr == OFS_CLASS);
      strobe.enSet     = (busAddr == OFS_EN_SET);
      strobe.enClr     = (busAddr == OFS_EN_CLR);
      strobe.swSet     = (busAddr == OFS_SW_SET);
      strobe.swClr     = (busAddr == OFS_SW_CLR);
      strobe.defWr     = (busAddr == OFS_DEFAULT);
      strobe.vecEnd    = (busAddr == OFS_VEC);
      strobe.slotCtlWr = inCtl && slotHit;
      strobe.slotAdrWr = inAdr && slotHit;
    end
    strobe.vecRead = busRd && (busAddr == OFS_VEC);
  end

  // winner search: a slot may win only above the best in-service slot
  always_comb begin
    blocked   = 1'b0;
    candFound = 1'b0;
    candSlot  = '0;
    svcFound  = 1'b0;
    svcSlot   = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (svcMask[i]) blocked = 1'b1;
      if (!blocked && slotActive[i] && !candFound) begin
        candFound = 1'b1;
        candSlot  = SLOT_W'(i);
      end
      if (svcMask[i] && !svcFound) begin
        svcFound = 1'b1;
        svcSlot  = SLOT_W'(i);
      end
    end
    outSlot    = candFound ? candSlot : svcSlot;
    useDefault = !candFound && !svcFound;
  end

  // in-service state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcMask <= '0;
    end else if (strobe.vecRead && candFound) begin
      svcMask[candSlot] <= 1'b1;
    end else if (strobe.vecEnd && svcFound) begin
      svcMask[svcSlot] <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  hwReq,
  input  logic [BUS_AW-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  strobe_t             strobe,
  input  logic [SLOT_W-1:0]   slotIdx,
  input  logic                slotHit,
  input  logic [SLOT_W-1:0]   outSlot,
  input  logic                useDefault,
  output logic [DATA_W-1:0]   busRdata,
  output logic                fiqOut,
  output logic                irqOut,
  output logic [NUM_SLOT-1:0] slotActive,
  output logic [NUM_SRC-1:0]  softReq,
  output logic [NUM_SRC-1:0]  enMask
);
  logic [NUM_SRC-1:0] classSel, rawReq, fiqAct, irqAct, wd;
  logic [DATA_W-1:0]  defAddr, vecAddr;
  logic [SRC_W-1:0]   slotSrc  [NUM_SLOT];
  logic               slotEn   [NUM_SLOT];
  logic [DATA_W-1:0]  slotAddr [NUM_SLOT];

  assign wd = busWdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      classSel <= '0;
      enMask   <= '0;
      softReq  <= '0;
      defAddr  <= '0;
      for (int i = 0; i < NUM_SLOT; i++) begin
        slotSrc[i]  <= '0;
        slotEn[i]   <= 1'b0;
        slotAddr[i] <= '0;
      end
    end else begin
      if (strobe.classWr) classSel <= wd;
      if (strobe.enSet)   enMask   <= enMask | wd;
      if (strobe.enClr)   enMask   <= enMask & ~wd;
      if (strobe.swSet)   softReq  <= softReq | wd;
      if (strobe.swClr)   softReq  <= softReq & ~wd;
      if (strobe.defWr)   defAddr  <= busWdata;
      if (strobe.slotCtlWr) begin
        slotSrc[slotIdx] <= busWdata[SRC_W-1:0];
        slotEn[slotIdx]  <= busWdata[SRC_W];
      end
      if (strobe.slotAdrWr) slotAddr[slotIdx] <= busWdata;
    end
  end

  assign rawReq = hwReq | softReq;
  assign fiqAct = rawReq & enMask & classSel;
  assign irqAct = rawReq & enMask & ~classSel;
  assign fiqOut = |fiqAct;
  assign irqOut = |irqAct;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    assign slotActive[g] = slotEn[g] && irqAct[slotSrc[g]];
  end

  assign vecAddr = useDefault ? defAddr : slotAddr[outSlot];

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_RAW:      busRdata = DATA_W'(rawReq);
      OFS_FIQ_STAT: busRdata = DATA_W'(fiqAct);
      OFS_IRQ_STAT: busRdata = DATA_W'(irqAct);
      OFS_CLASS:    busRdata = DATA_W'(classSel);
      OFS_EN_SET:   busRdata = DATA_W'(enMask);
      OFS_SW_SET:   busRdata = DATA_W'(softReq);
      OFS_VEC:      busRdata = vecAddr;
      OFS_DEFAULT:  busRdata = defAddr;
      default: begin
        if (slotHit && busAddr[5:4] == REGION_CTL)
          busRdata = DATA_W'({slotEn[slotIdx], slotSrc[slotIdx]});
        else if (slotHit && busAddr[5:4] == REGION_ADR)
          busRdata = slotAddr[slotIdx];
      end
    endcase
  end
endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  localparam int SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic [5:0]         busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               fiqOut,
  output logic               irqOut
);
  strobe_t             strobe;
  logic [SLOT_W-1:0]   slotIdx, outSlot;
  logic                slotHit, useDefault;
  logic [NUM_SLOT-1:0] slotActive, svcMask;
  logic [NUM_SRC-1:0]  softReq, enMask;

  intc_control #(.NUM_SLOT(NUM_SLOT)) u_control (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .slotActive(slotActive), .strobe(strobe), .slotIdx(slotIdx),
    .slotHit(slotHit), .outSlot(outSlot), .useDefault(useDefault),
    .svcMask(svcMask)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .slotIdx(slotIdx),
    .slotHit(slotHit), .outSlot(outSlot), .useDefault(useDefault),
    .busRdata(busRdata), .fiqOut(fiqOut), .irqOut(irqOut),
    .slotActive(slotActive), .softReq(softReq), .enMask(enMask)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_SRC-1:0]  hwReq,
  input logic [5:0]          busAddr,
  input logic                busWr,
  input logic                busRd,
  input logic [DATA_W-1:0]   busWdata,
  input logic                fiqOut,
  input logic                irqOut,
  input logic [NUM_SRC-1:0]  softReq,
  input logic [NUM_SRC-1:0]  enMask,
  input logic [NUM_SLOT-1:0] svcMask
);
  logic vecAccess;
  assign vecAccess = (busAddr == OFS_VEC) && (busWr || busRd);

  p_sw_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_SW_SET) |=>
      ((softReq & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  p_sw_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_SW_CLR) |=>
      ((softReq & $past(busWdata[NUM_SRC-1:0])) == '0));

  p_en_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_EN_SET) |=>
      ((enMask & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  p_en_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_EN_CLR) |=>
      ((enMask & $past(busWdata[NUM_SRC-1:0])) == '0));

  p_fiq_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> ((hwReq | softReq) != '0));

  p_irq_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((hwReq | softReq) != '0));

  p_read_no_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == OFS_VEC) |=>
      ($countones(svcMask) >= $countones($past(svcMask))));

  p_end_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFS_VEC && svcMask != '0) |=>
      ($countones(svcMask) + 1 == $countones($past(svcMask))));

  p_svc_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !vecAccess |=> $stable(svcMask));
endmodule

bind intc_vec_top intc_checker #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .hwReq(hwReq), .busAddr(busAddr), .busWr(busWr),
  .busRd(busRd), .busWdata(busWdata), .fiqOut(fiqOut), .irqOut(irqOut),
  .softReq(softReq), .enMask(enMask), .svcMask(svcMask)
);

// File: tb/test_intc_vec_top.sv
module test_intc_vec_top;
  localparam logic [5:0] A_RAW = 6'h00, A_FIQS = 6'h01, A_IRQS = 6'h02,
    A_CLASS = 6'h03, A_ENS = 6'h04, A_ENC = 6'h05, A_SWS = 6'h06,
    A_SWC = 6'h07, A_VEC = 6'h08, A_DEF = 6'h09, A_CTL = 6'h10, A_ADR = 6'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwReq = '0;
  logic [5:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fiqOut, irqOut;
  int          errors = 0, checks = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  intc_vec_top i_intc_vec_top (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .fiqOut(fiqOut), .irqOut(irqOut)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  // driver: push the expected read value, then issue the read
  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic pins(input logic ef, input logic ei, input string tag);
    @(negedge clk);
    checks++;
    if (fiqOut !== ef || irqOut !== ei) begin
      errors++;
      $display("FAIL %s: fiq/irq actual=%b%b expected=%b%b", tag, fiqOut, irqOut, ef, ei);
    end
  endtask

  // monitor: compare read data against the scoreboard head
  always @(negedge clk) begin
    if (busRd) begin
      item_t it;
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read actual=%h expected=none", busRdata);
      end else begin
        it = sbq.pop_front();
        if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, busAddr, busRdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    pins(1'b0, 1'b0, "R1");
    rd(A_RAW, 32'h0, "R1");
    rd(A_ENS, 32'h0, "R1");
    rd(A_CLASS, 32'h0, "R1");
    rd(A_VEC, 32'h0, "R1");
    // R2 / R4: raw visible, disabled source gated
    hwReq = 32'h8;
    rd(A_RAW, 32'h8, "R2");
    rd(A_IRQS, 32'h0, "R4");
    pins(1'b0, 1'b0, "R4");
    wr(A_ENS, 32'h8);
    pins(1'b0, 1'b1, "R4");
    rd(A_ENS, 32'h8, "R4");
    rd(A_IRQS, 32'h8, "R5");
    // R5 class select
    wr(A_CLASS, 32'h8);
    pins(1'b1, 1'b0, "R5");
    rd(A_FIQS, 32'h8, "R5");
    rd(A_IRQS, 32'h0, "R5");
    wr(A_CLASS, 32'h0);
    wr(A_ENC, 32'h8);
    pins(1'b0, 1'b0, "R4");
    rd(A_ENS, 32'h0, "R4");
    hwReq = '0;
    // R3 software requests
    wr(A_ENS, 32'h80);
    wr(A_SWS, 32'h80);
    rd(A_RAW, 32'h80, "R3");
    rd(A_SWS, 32'h80, "R3");
    pins(1'b0, 1'b1, "R3");
    wr(A_SWC, 32'h80);
    rd(A_RAW, 32'h0, "R3");
    pins(1'b0, 1'b0, "R3");
    // R2 hardware OR software
    hwReq = 32'h2;
    wr(A_SWS, 32'h4);
    rd(A_RAW, 32'h6, "R2");
    wr(A_SWC, 32'h4);
    hwReq = '0;
    // R6 default address for an unclaimed source
    wr(A_DEF, 32'hDEF0_0000);
    wr(A_ENS, (32'h1 << 10) | (32'h1 << 12) | (32'h1 << 13));
    hwReq[10] = 1'b1;
    rd(A_VEC, 32'hDEF0_0000, "R6");
    // R7 slot programming
    wr(A_ADR + 6'd2, 32'hA000_0002);
    wr(A_CTL + 6'd2, 32'h2A);
    rd(A_CTL + 6'd2, 32'h2A, "R7");
    rd(A_VEC, 32'hA000_0002, "R7");
    wr(A_ADR + 6'd0, 32'hA000_0000);
    wr(A_CTL + 6'd0, 32'h2C);
    wr(A_ADR + 6'd5, 32'hA000_0005);
    wr(A_CTL + 6'd5, 32'h2D);
    // R8 nesting: slot 2 in service
    hwReq[13] = 1'b1;
    rd(A_VEC, 32'hA000_0002, "R8");
    hwReq[12] = 1'b1;
    rd(A_VEC, 32'hA000_0000, "R8");
    hwReq[12] = 1'b0;
    wr(A_VEC, 32'h0);
    rd(A_VEC, 32'hA000_0002, "R8");
    wr(A_VEC, 32'h0);
    hwReq[10] = 1'b0;
    rd(A_VEC, 32'hA000_0005, "R7");
    wr(A_VEC, 32'h0);
    hwReq[10] = 1'b1;
    rd(A_VEC, 32'hA000_0002, "R7");
    wr(A_VEC, 32'h0);
    // R9 claimed source moved to fast class
    wr(A_CLASS, 32'h1 << 10);
    rd(A_VEC, 32'hA000_0005, "R9");
    pins(1'b1, 1'b1, "R9");
    wr(A_VEC, 32'h0);
    wr(A_CLASS, 32'h0);
    // R6 disabled slot falls back to default
    wr(A_CTL + 6'd2, 32'h0A);
    rd(A_VEC, 32'hA000_0005, "R7");
    wr(A_VEC, 32'h0);
    hwReq[13] = 1'b0;
    rd(A_VEC, 32'hDEF0_0000, "R6");
    // R7 lowest slot with highest source
    wr(A_ADR + 6'd15, 32'hA000_000F);
    wr(A_CTL + 6'd15, 32'h3F);
    wr(A_ENS, 32'h8000_0000);
    hwReq = 32'h8000_0000;
    rd(A_VEC, 32'hA000_000F, "R7");
    wr(A_VEC, 32'h0);
    repeat (2) @(posedge clk);
    if (sbq.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", sbq.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule